// File: doc/BRIEF.md
# Loadable Countdown Event Timer

The block is a single countdown timer meant to serve as the event source of a processor system. Software writes a wide reload value as two 32-bit words, then sets a control word that starts the count, picks between a repeating and a single-shot mode, and lets the pending event reach the interrupt line. Each time the count runs out, a sticky pending flag is raised. Software clears it by writing a one to the status location.

In repeating mode the counter reloads itself on the same cycle that it expires, so a reload value of N gives one event every N+1 clock cycles. In single-shot mode the counter stops at zero after one event and stays there until software turns the enable off and back on. The interrupt output is a level that stays high while the flag is pending and unmasked. Register access is a plain single-cycle write strobe with a combinational read port. Timer and bus share one clock.

Top module: `evtmr_top`

## Requirements
- R1: After reset every readable location returns 0 and `irq` is low.
- R2: The low reload word is at byte offset 0x00 and the high word at 0x04. Both read back as written. The control word at 0x10 reads back in bits 2:0, where bit 0 = enable, bit 1 = mode (0 repeating, 1 single-shot) and bit 2 = interrupt unmask. Any other offset reads 0.
- R3: A write that changes the enable from 0 to 1 loads the full 64-bit reload value {high, low}. The status flag is set N+1 cycles after that write edge. A non-zero high word delays the expiry accordingly.
- R4: In repeating mode the counter reloads on the expiry cycle, giving one expiry every N+1 cycles.
- R5: In single-shot mode the counter stops after one expiry and raises no further event until it is disabled and then re-enabled. Re-enabling restarts a full count.
- R6: Expiry sets the pending flag (status offset 0x18, bit 0) whatever the unmask bit holds.
- R7: `irq` is high exactly when the pending flag and the unmask bit are both 1.
- R8: Writing 1 to status bit 0 clears the flag and writing 0 leaves it. If an expiry falls on the same cycle as a clear, the flag stays set.
- R9: While the enable is 0 the count is frozen and no expiry occurs.
- R10: A reload value of 0 in repeating mode expires on every cycle.
- R11: A reload word written while the timer runs does not disturb the count in progress. It takes effect at the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the register port and the counter |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| addr | input | 5 | Byte offset for both read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| irq | output | 1 | Level-high interrupt |

## Verification
A table of reload values (1, 2, 3, 5, 7, 12) is run in both modes with the mask open and closed. The first expiry must land exactly N+1 cycles after the enabling write, which separates an off-by-one in the load or compare from a correct count. The second period then tells repeating mode from single-shot mode. Directed cases cover a reload of zero, which turns a clear into a collision with an expiry, and a non-zero high word, which shows that both words reach the counter. They also cover a reload word rewritten in mid-count, which separates loading at the next reload from loading at once, and a pause with the enable off, which must freeze the count rather than clear it.

// File: rtl/evtmr_pkg.sv
package evtmr_pkg;
  localparam int unsigned ADDR_W = 5;

  localparam logic [ADDR_W-1:0] OFS_LOAD0 = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 5'h18;

  localparam int unsigned WORD_BYTES = 4;

  // control word layout: bit 0 run, bit 1 oneshot, bit 2 unmask
  typedef struct packed {
    logic unmask;
    logic oneshot;
    logic run;
  } ctl_t;

  localparam int unsigned CTL_W = $bits(ctl_t);
endpackage

// File: rtl/evtmr_regs.sv
module evtmr_regs
  import evtmr_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned NW = 2,
  localparam int unsigned CW = DW * NW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  input  logic              pend,
  output logic [DW-1:0]     rdata,
  output logic [CW-1:0]     reload,
  output ctl_t              ctl,
  output logic              arm,
  output logic              clr
);

  // reload words, one register per word
  for (genvar k = 0; k < NW; k++) begin : g_ld
    logic          sel;
    logic [DW-1:0] word_q;
    logic [DW-1:0] word_d;

    assign sel = wr_en && (addr == OFS_LOAD0 + ADDR_W'(WORD_BYTES * k));

    always_comb begin
      word_d = word_q;
      if (sel) word_d = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q <= '0;
      else        word_q <= word_d;
    end

    assign reload[k*DW +: DW] = word_q;
  end

  // control word
  logic ctl_wr;
  ctl_t ctl_q;
  ctl_t ctl_d;

  assign ctl_wr = wr_en && (addr == OFS_CTRL);

  always_comb begin
    ctl_d = ctl_q;
    if (ctl_wr) ctl_d = ctl_t'(wdata[CTL_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_d;
  end

  assign ctl = ctl_q;
  assign arm = ctl_wr && wdata[0] && !ctl_q.run;
  assign clr = wr_en && (addr == OFS_STAT) && wdata[0];

  // read mux
  always_comb begin
    rdata = '0;
    for (int k = 0; k < NW; k++) begin
      if (addr == OFS_LOAD0 + ADDR_W'(WORD_BYTES * k)) rdata = reload[k*DW +: DW];
    end
    if (addr == OFS_CTRL) rdata[CTL_W-1:0] = ctl_q;
    if (addr == OFS_STAT) rdata[0] = pend;
  end

  // R2: control word changes only through its own write
  p_ctl_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_wr |=> $stable(ctl_q));

  // R3: an arming write leaves the timer running
  p_arm_runs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> ctl_q.run);

endmodule

// File: rtl/evtmr_count.sv
module evtmr_count #(
  parameter int unsigned CW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          oneshot,
  input  logic          arm,
  input  logic [CW-1:0] reload,
  output logic          expire
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          done_q;
  logic          done_d;

  always_comb begin
    cnt_d  = cnt_q;
    done_d = done_q;
    expire = 1'b0;
    if (arm) begin
      cnt_d  = reload;
      done_d = 1'b0;
    end else if (run && !done_q) begin
      if (cnt_q == '0) begin
        expire = 1'b1;
        if (oneshot) done_d = 1'b1;
        else         cnt_d  = reload;
      end else begin
        cnt_d = cnt_q - CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  // R3: arming loads the whole reload value
  p_load_on_arm_r3: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (cnt_q == $past(reload)));

  // R4: repeating mode reloads on the expiry cycle
  p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !oneshot) |=> (cnt_q == $past(reload)));

  // R5: single-shot expiry parks the counter at zero
  p_halt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && oneshot) |=> (done_q && cnt_q == '0));

  // R9: a stopped counter keeps its value
  p_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !arm) |=> $stable(cnt_q));

endmodule

// File: rtl/evtmr_irq.sv
module evtmr_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic clr,
  input  logic unmask,
  output logic pend,
  output logic irq
);

  logic pend_q;
  logic pend_d;

  always_comb begin
    pend_d = pend_q;
    if (clr)    pend_d = 1'b0;
    if (expire) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign pend = pend_q;
  assign irq  = pend_q & unmask;

  // R6: every expiry leaves the flag set
  p_set_on_expire_r6: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> pend_q);

  // R8: a clear without a colliding expiry drops the flag
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !expire) |=> !pend_q);

  // R8: the flag is sticky without a clear
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !clr) |=> pend_q);

endmodule

// File: rtl/evtmr_top.sv
module evtmr_top
  import evtmr_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned NW = 2,
  localparam int unsigned CW = DW * NW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic              irq
);

  // reset: asserted at once, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end

  assign rst_int_n = rst_sync_q[1];

  logic [CW-1:0] reload;
  ctl_t          ctl;
  logic          arm;
  logic          clr;
  logic          expire;
  logic          pend;

  evtmr_regs #(.DW(DW), .NW(NW)) u_regs (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .wr_en  (wr_en),
    .addr   (addr),
    .wdata  (wdata),
    .pend   (pend),
    .rdata  (rdata),
    .reload (reload),
    .ctl    (ctl),
    .arm    (arm),
    .clr    (clr)
  );

  evtmr_count #(.CW(CW)) u_count (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .run     (ctl.run),
    .oneshot (ctl.oneshot),
    .arm     (arm),
    .reload  (reload),
    .expire  (expire)
  );

  evtmr_irq u_irq (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .expire (expire),
    .clr    (clr),
    .unmask (ctl.unmask),
    .pend   (pend),
    .irq    (irq)
  );

  // R7: the line never rises while masked
  p_irq_masked_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    irq |-> ctl.unmask);

  // R7: a pending, unmasked event always reaches the line
  p_irq_shown_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (pend && ctl.unmask) |-> irq);

endmodule

// File: tb/sim_evtmr_top.sv
module sim_evtmr_top;
  import evtmr_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int nchk = 0;
  int nerr = 0;
  bit ended = 1'b0;

  always #4 clk = ~clk;

  evtmr_top u0 (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .addr  (addr),
    .wdata (wdata),
    .rdata (rdata),
    .irq   (irq)
  );

  // vector: {reload[7:0], oneshot, unmask}
  localparam int NV = 6;
  localparam logic [9:0] VEC [NV] = '{
    {8'd3, 1'b0, 1'b1}, {8'd7, 1'b0, 1'b0}, {8'd1, 1'b0, 1'b1},
    {8'd5, 1'b1, 1'b1}, {8'd12, 1'b1, 1'b0}, {8'd2, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic chk_stat(input string req, input logic exp);
    logic [31:0] v;
    rd(OFS_STAT, v);
    check(req, v, {31'b0, exp});
  endtask

  initial begin
    logic [31:0] v;
    step(2);
    // R1: reset state
    for (int a = 0; a < 32; a += 4) begin
      rd(5'(a), v);
      check("R1 reset read", v, 32'h0);
    end
    check("R1 reset irq", {31'b0, irq}, 32'h0);
    rst_n = 1'b1;
    step(4);

    // R2: readback
    wr(OFS_LOAD0, 32'hA5C3_0F1E);
    wr(5'h04, 32'h1234_5678);
    wr(OFS_CTRL, 32'hFFFF_FFF6);
    rd(OFS_LOAD0, v); check("R2 low word", v, 32'hA5C3_0F1E);
    rd(5'h04, v);     check("R2 high word", v, 32'h1234_5678);
    rd(OFS_CTRL, v);  check("R2 control", v, 32'h6);
    rd(5'h08, v);     check("R2 unmapped", v, 32'h0);
    check("R7 masked idle", {31'b0, irq}, 32'h0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      int n = int'(VEC[i][9:2]);
      logic m = VEC[i][1];
      logic u = VEC[i][0];
      wr(OFS_CTRL, 32'h0);
      wr(OFS_LOAD0, 32'(n));
      wr(5'h04, 32'h0);
      wr(OFS_STAT, 32'h1);
      wr(OFS_CTRL, {29'b0, u, m, 1'b1});
      step(n);
      chk_stat("R3 before first expiry", 1'b0);
      step(1);
      chk_stat("R3 R6 first expiry", 1'b1);
      check("R7 irq follows mask", {31'b0, irq}, {31'b0, u});
      wr(OFS_STAT, 32'h1);
      if (!m) begin
        step(n - 1);
        chk_stat("R4 before second expiry", 1'b0);
        step(1);
        chk_stat("R4 second expiry", 1'b1);
      end else begin
        step(2 * n + 4);
        chk_stat("R5 no second expiry", 1'b0);
        check("R5 irq low", {31'b0, irq}, 32'h0);
      end
    end

    // R9: pause freezes, re-enable reloads
    wr(OFS_CTRL, 32'h0);
    wr(OFS_LOAD0, 32'd4);
    wr(5'h04, 32'h0);
    wr(OFS_STAT, 32'h1);
    wr(OFS_CTRL, 32'h1);
    step(1);
    wr(OFS_CTRL, 32'h0);
    step(10);
    chk_stat("R9 frozen while off", 1'b0);
    wr(OFS_CTRL, 32'h1);
    step(4);
    chk_stat("R9 re-enable full count", 1'b0);
    step(1);
    chk_stat("R9 re-enable expiry", 1'b1);

    // R8: writing 0 keeps the flag
    wr(OFS_STAT, 32'h0);
    chk_stat("R8 zero write ignored", 1'b1);

    // R10 and R8 collision
    wr(OFS_CTRL, 32'h0);
    wr(OFS_LOAD0, 32'd0);
    wr(OFS_STAT, 32'h1);
    chk_stat("R8 clear", 1'b0);
    wr(OFS_CTRL, 32'h1);
    step(1);
    chk_stat("R10 zero reload expiry", 1'b1);
    wr(OFS_STAT, 32'h1);
    chk_stat("R8 expiry beats clear", 1'b1);
    wr(OFS_CTRL, 32'h0);
    wr(OFS_STAT, 32'h1);
    chk_stat("R8 clear after stop", 1'b0);

    // R3: high word counts
    wr(OFS_LOAD0, 32'd2);
    wr(5'h04, 32'd1);
    wr(OFS_CTRL, 32'h1);
    step(20);
    chk_stat("R3 high word delays expiry", 1'b0);
    wr(OFS_CTRL, 32'h0);
    wr(5'h04, 32'h0);
    wr(OFS_STAT, 32'h1);

    // R11: live reload update
    wr(OFS_LOAD0, 32'd4);
    wr(OFS_CTRL, 32'h1);
    wr(OFS_LOAD0, 32'd9);
    step(3);
    chk_stat("R11 current count kept", 1'b0);
    step(1);
    chk_stat("R11 first expiry on old value", 1'b1);
    wr(OFS_STAT, 32'h1);
    step(8);
    chk_stat("R11 new value pending", 1'b0);
    step(1);
    chk_stat("R11 new value used", 1'b1);

    // R5: single-shot restart
    wr(OFS_CTRL, 32'h0);
    wr(OFS_LOAD0, 32'd3);
    wr(OFS_STAT, 32'h1);
    wr(OFS_CTRL, 32'h3);
    step(3);
    chk_stat("R5 before shot", 1'b0);
    step(1);
    chk_stat("R5 shot", 1'b1);
    wr(OFS_STAT, 32'h1);
    step(6);
    chk_stat("R5 halted", 1'b0);
    wr(OFS_CTRL, 32'h2);
    wr(OFS_CTRL, 32'h3);
    step(3);
    chk_stat("R5 restart counting", 1'b0);
    step(1);
    chk_stat("R5 restart shot", 1'b1);

    if (!ended) begin
      ended = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!ended) begin
      ended = 1'b1;
      nchk++;
      nerr++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

endmodule